// File: doc/BRIEF.md
# Page-Hit-Limited DRAM Request Arbiter

This block picks the next DRAM request to issue from a small pool of request slots. Each slot carries a valid flag, a chip-select number, a bank and a row. The arbiter keeps its own table of open rows, one entry per bank of each chip select. A request whose row matches the open row of its bank is a page hit. Page hits are cheap to serve, so they normally win over requests that would need a new row opened.

A stream of page hits could hold off a row-miss request indefinitely. To prevent this, each chip select has one run counter shared by all of its banks. The counter counts back-to-back page-hit grants to that chip select. Once it reaches a programmable limit, a pending row-miss request to the same chip select goes ahead of further hits. The limit comes from a 2-bit setting, and 8 is the recommended value.

The grant is registered. It appears as a one-hot vector with a valid strobe, one clock after the requests are sampled. A granted row miss opens its row in the table. Among requests of the same class, a round-robin pointer starts the search at the slot after the previous grant. Command sequencing, DRAM timing and refresh are handled elsewhere.

Top module: `page_hit_arbiter`

## Requirements
- R1: A valid request is a page hit when its bank in its chip select has a recorded open row equal to the request's row; otherwise it is a row miss.
- R2: When no cap applies, a pending page hit is granted in preference to any pending row miss.
- R3: A single consecutive-hit counter per chip select counts page-hit grants to any bank of that chip select.
- R4: When a chip select's counter has reached the limit and a row miss to that same chip select is pending, the next grant goes to a row miss. A capped counter does not hold back hits when the only pending misses belong to other chip selects.
- R5: `hit_limit_sel` encodes the limit as 2'b00 = 1, 2'b01 = 4, 2'b10 = 8 and 2'b11 = 16 consecutive page hits.
- R6: Granting a row miss clears the counter of that chip select only; counters of other chip selects keep their value.
- R7: With the limit reached and no row miss pending for that chip select, page hits are still granted, and the counter stays at the limit.
- R8: Among candidate requests of the chosen class, the grant goes to the first valid slot at or after the slot that follows the last granted slot, wrapping from the highest slot to slot 0.
- R9: Granting a row miss records the request's row as the open row of its bank; the row previously open there then counts as a miss.
- R10: Reset clears all counters, marks every bank as having no open row, sets the round-robin start to slot 0, and holds `grant_valid` and `grant` at zero.
- R11: A grant appears one clock edge after the requests are sampled. `grant` is one-hot, names a slot that was valid at that edge, and is zero with `grant_valid` low whenever no request was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_SLOTS | One valid flag per request slot |
| req_cs | input | NUM_SLOTS*CS_W | Chip-select number of each slot, slot 0 in the low bits |
| req_bank | input | NUM_SLOTS*BANK_W | Bank number of each slot |
| req_row | input | NUM_SLOTS*ROW_W | Row address of each slot |
| hit_limit_sel | input | 2 | Consecutive page-hit limit code |
| grant | output | NUM_SLOTS | One-hot granted slot |
| grant_valid | output | 1 | A grant is presented this cycle |

## Verification
The arbiter is first driven with hit-versus-miss pairs. These separate plain hit preference from the forced miss, both when the counter sits below the limit and when it sits at it. A second set places the hits in different banks of one chip select and the misses in the other chip select. This shows whether the counter is shared across banks and kept apart between chip selects. Long runs of a hit competing with one pending miss under each limit code count the hits before the miss is served. Requests with equal class and shifting slot positions, together with reset in the middle of a run, cover the round-robin start and the cleared open-row state.

// File: rtl/pharb_pkg.sv
package pharb_pkg;

   // Width of the consecutive-hit counter; holds the largest selectable limit.
   localparam int RUN_CNT_W = 5;

   // Maps the 2-bit limit code onto a hit count.
   function automatic logic [RUN_CNT_W-1:0] decode_limit(input logic [1:0] code);
      logic [RUN_CNT_W-1:0] lim;
      case (code)
         2'b00:   lim = RUN_CNT_W'(1);
         2'b01:   lim = RUN_CNT_W'(4);
         2'b10:   lim = RUN_CNT_W'(8);
         default: lim = RUN_CNT_W'(16);
      endcase
      return lim;
   endfunction

endpackage

// File: rtl/pharb_row_table.sv
module pharb_row_table #(
   parameter int NUM_SLOTS = 4,
   parameter int NUM_CS    = 2,
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 8,
   parameter int CS_W      = 1,
   parameter int BANK_W    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS*CS_W-1:0]   lk_cs,
   input  logic [NUM_SLOTS*BANK_W-1:0] lk_bank,
   input  logic [NUM_SLOTS*ROW_W-1:0]  lk_row,
   output logic [NUM_SLOTS-1:0]        lk_hit,
   input  logic                        upd_en,
   input  logic [CS_W-1:0]             upd_cs,
   input  logic [BANK_W-1:0]           upd_bank,
   input  logic [ROW_W-1:0]            upd_row
);

   localparam int ENTRIES = NUM_CS * NUM_BANKS;
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] open_vld_q;
   logic [ROW_W-1:0]   open_row_q [ENTRIES];

   function automatic int entry_of(input logic [CS_W-1:0] cs, input logic [BANK_W-1:0] bank);
      if (int'(cs) >= NUM_CS || int'(bank) >= NUM_BANKS) return ENTRIES;
      return int'(cs) * NUM_BANKS + int'(bank);
   endfunction

   // One comparator per request slot.
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lookup
      int               full;
      logic [IDX_W-1:0] ix;
      always_comb begin
         full      = entry_of(lk_cs[s*CS_W +: CS_W], lk_bank[s*BANK_W +: BANK_W]);
         ix        = IDX_W'(full);
         lk_hit[s] = 1'b0;
         if (full < ENTRIES)
            lk_hit[s] = open_vld_q[ix] && (open_row_q[ix] == lk_row[s*ROW_W +: ROW_W]);
      end
   end

   int               ufull;
   logic [IDX_W-1:0] uix;
   logic             uwrite;
   always_comb begin
      ufull  = entry_of(upd_cs, upd_bank);
      uix    = IDX_W'(ufull);
      uwrite = upd_en && (ufull < ENTRIES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      open_vld_q      <= '0;
      else if (uwrite) open_vld_q[uix] <= 1'b1;
   end

   // Row contents need no reset: the valid bits gate every comparison.
   always_ff @(posedge clk) begin
      if (uwrite) open_row_q[uix] <= upd_row;
   end

   // R9: a granted miss leaves its row recorded as open.
   p_row_opened_r9: assert property (@(posedge clk) disable iff (!rst_n)
      uwrite |=> open_vld_q[$past(uix)] && (open_row_q[$past(uix)] == $past(upd_row)));

endmodule

// File: rtl/pharb_run_counter.sv
module pharb_run_counter
   import pharb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RUN_CNT_W-1:0] limit,
   input  logic                 gnt_en,
   input  logic                 gnt_hit,
   output logic                 at_limit
);

   logic [RUN_CNT_W-1:0] cnt_q;

   assign at_limit = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (gnt_en) begin
         if (!gnt_hit)      cnt_q <= '0;
         else if (at_limit) cnt_q <= limit;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: a miss grant to this chip select restarts the run.
   p_miss_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_en && !gnt_hit) |=> (cnt_q == '0));

   // R3: each hit grant below the limit advances the shared count by one.
   p_hit_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_en && gnt_hit && !at_limit) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7: hit grants at the limit keep the count pinned.
   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_en && gnt_hit && at_limit) |=> (cnt_q == $past(limit)));

   // R6: grants to other chip selects leave this count alone.
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_en |=> $stable(cnt_q));

endmodule

// File: rtl/pharb_rr_pick.sv
module pharb_rr_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     cand,
   input  logic [IDX_W-1:0] start,
   output logic [N-1:0]     pick,
   output logic [IDX_W-1:0] pick_idx,
   output logic             found
);

   always_comb begin
      int j;
      j        = 0;
      pick     = '0;
      pick_idx = '0;
      found    = 1'b0;
      for (int k = 0; k < N; k++) begin
         j = (int'(start) + k) % N;
         if (!found && cand[j]) begin
            found    = 1'b1;
            pick[j]  = 1'b1;
            pick_idx = IDX_W'(j);
         end
      end
   end

   // R8: the pick is always one of the candidates, and exists whenever one does.
   always_comb begin
      p_pick_member_r8: assert ((pick & ~cand) == '0);
      p_pick_found_r8:  assert (found == (|cand));
   end

endmodule

// File: rtl/page_hit_arbiter.sv
module page_hit_arbiter
   import pharb_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int NUM_CS    = 2,
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 8,
   localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS-1:0]        req_valid,
   input  logic [NUM_SLOTS*CS_W-1:0]   req_cs,
   input  logic [NUM_SLOTS*BANK_W-1:0] req_bank,
   input  logic [NUM_SLOTS*ROW_W-1:0]  req_row,
   input  logic [1:0]                  hit_limit_sel,
   output logic [NUM_SLOTS-1:0]        grant,
   output logic                        grant_valid
);

   localparam int SLOT_W = $clog2(NUM_SLOTS);

   // Elaboration-time parameter checks.
   if (NUM_SLOTS < 2) begin : g_chk_slots
      $error("page_hit_arbiter: NUM_SLOTS must be at least 2");
   end
   if (NUM_CS < 1 || NUM_BANKS < 1) begin : g_chk_geom
      $error("page_hit_arbiter: NUM_CS and NUM_BANKS must be at least 1");
   end
   if (ROW_W < 1) begin : g_chk_row
      $error("page_hit_arbiter: ROW_W must be at least 1");
   end

   logic [NUM_SLOTS-1:0] slot_hit, slot_blocked, tier_hit, tier_miss, cand, pick;
   logic [CS_W-1:0]      slot_cs [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] slot_cs_ok;
   logic [NUM_CS-1:0]    miss_cs, at_limit;
   logic [SLOT_W-1:0]    ptr_q, pick_idx, ptr_nxt;
   logic                 found, take, gnt_hit;
   logic [CS_W-1:0]      g_cs;
   logic [BANK_W-1:0]    g_bank;
   logic [ROW_W-1:0]     g_row;
   logic [RUN_CNT_W-1:0] limit;

   assign limit = decode_limit(hit_limit_sel);

   pharb_row_table #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_CS(NUM_CS), .NUM_BANKS(NUM_BANKS),
      .ROW_W(ROW_W), .CS_W(CS_W), .BANK_W(BANK_W)
   ) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_cs    (req_cs),
      .lk_bank  (req_bank),
      .lk_row   (req_row),
      .lk_hit   (slot_hit),
      .upd_en   (take && !gnt_hit),
      .upd_cs   (g_cs),
      .upd_bank (g_bank),
      .upd_row  (g_row)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_cs[s]    = req_cs[s*CS_W +: CS_W];
      assign slot_cs_ok[s] = (int'(slot_cs[s]) < NUM_CS);
   end

   // Pending row misses, grouped by chip select.
   always_comb begin
      miss_cs = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         for (int c = 0; c < NUM_CS; c++)
            if (req_valid[s] && !slot_hit[s] && slot_cs_ok[s] && int'(slot_cs[s]) == c)
               miss_cs[c] = 1'b1;
   end

   // A hit is held back only when its own chip select is capped and owes a miss.
   always_comb begin
      for (int s = 0; s < NUM_SLOTS; s++)
         slot_blocked[s] = slot_hit[s] && slot_cs_ok[s] &&
                           at_limit[slot_cs[s]] && miss_cs[slot_cs[s]];
   end

   assign tier_hit  = req_valid & slot_hit & ~slot_blocked;
   assign tier_miss = req_valid & ~slot_hit;
   assign cand      = (|tier_hit) ? tier_hit : tier_miss;

   pharb_rr_pick #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_pick (
      .cand     (cand),
      .start    (ptr_q),
      .pick     (pick),
      .pick_idx (pick_idx),
      .found    (found)
   );

   assign take    = found;
   assign gnt_hit = |(pick & slot_hit);
   assign g_cs    = slot_cs[pick_idx];
   assign g_bank  = req_bank[pick_idx*BANK_W +: BANK_W];
   assign g_row   = req_row[pick_idx*ROW_W +: ROW_W];

   for (genvar c = 0; c < NUM_CS; c++) begin : g_cs_run
      pharb_run_counter u_run (
         .clk      (clk),
         .rst_n    (rst_n),
         .limit    (limit),
         .gnt_en   (take && (int'(g_cs) == c)),
         .gnt_hit  (gnt_hit),
         .at_limit (at_limit[c])
      );
   end

   // Pointer wrap: free-running for a power-of-two slot count, compared otherwise.
   if ((NUM_SLOTS & (NUM_SLOTS - 1)) == 0) begin : g_ptr_pow2
      assign ptr_nxt = pick_idx + 1'b1;
   end else begin : g_ptr_mod
      assign ptr_nxt = (pick_idx == SLOT_W'(NUM_SLOTS - 1)) ? '0 : pick_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant       <= '0;
         grant_valid <= 1'b0;
         ptr_q       <= '0;
      end else begin
         grant       <= take ? pick : '0;
         grant_valid <= take;
         if (take) ptr_q <= ptr_nxt;
      end
   end

   // R11: the grant is one-hot and only present with its strobe.
   p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $onehot(grant));
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> (grant == '0));
   // R11: the granted slot was requesting at the sampling edge.
   p_from_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_valid) |=> grant_valid && ((grant & $past(req_valid)) != '0));
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_valid) |=> !grant_valid);
   // R4: no hit is served while its chip select is capped and owes a miss.
   p_cap_forces_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && gnt_hit) |-> !(at_limit[g_cs] && miss_cs[g_cs]));
   // R2: an eligible hit beats every miss.
   p_hit_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|tier_hit) |-> gnt_hit);

endmodule

// File: tb/page_hit_arbiter_test.sv
`timescale 1ns/1ps
module page_hit_arbiter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req_valid;
   logic [3:0]  req_cs;
   logic [7:0]  req_bank;
   logic [31:0] req_row;
   logic [1:0]  lim_sel;
   logic [3:0]  grant;
   logic        grant_valid;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   page_hit_arbiter uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_cs        (req_cs),
      .req_bank      (req_bank),
      .req_row       (req_row),
      .hit_limit_sel (lim_sel),
      .grant         (grant),
      .grant_valid   (grant_valid)
   );

   // Slot encoding in vectors: {cs[0], bank[1:0], row[7:0]}.
   function automatic logic [10:0] s(input int cs, input int b, input int r);
      return {1'(cs), 2'(b), 8'(r)};
   endfunction

   localparam logic [10:0] Z = '0;

   typedef struct packed {
      logic [1:0]       lim;
      logic [3:0]       vld;
      logic [3:0][10:0] slot;
      logic [3:0]       exp;
      logic [3:0]       tag;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{2'b10, 4'b0001, {Z, Z, Z, s(0,0,'h10)},                    4'b0001, 4'd1},  // R1 empty table: miss granted
      '{2'b10, 4'b0011, {Z, Z, s(0,0,'h10), s(0,1,'h20)},          4'b0010, 4'd2},  // R2 hit beats miss
      '{2'b10, 4'b0101, {Z, s(1,0,'h30), Z, s(0,1,'h20)},          4'b0100, 4'd8},  // R8 start after last grant
      '{2'b10, 4'b0011, {Z, Z, s(0,2,'h40), s(0,1,'h20)},          4'b0001, 4'd8},  // R8 wrap to slot 0
      '{2'b00, 4'b1010, {s(0,2,'h40), Z, s(0,0,'h10), Z},          4'b0010, 4'd2},  // R2 below limit 1
      '{2'b00, 4'b1010, {s(0,2,'h40), Z, s(0,0,'h10), Z},          4'b1000, 4'd4},  // R4 cap forces miss
      '{2'b00, 4'b0101, {Z, s(0,3,'h50), Z, s(0,1,'h20)},          4'b0001, 4'd3},  // R3 hit in bank 1
      '{2'b00, 4'b0110, {Z, s(0,3,'h50), s(0,0,'h10), Z},          4'b0100, 4'd3},  // R3 bank 0 hit capped by bank 1 run
      '{2'b00, 4'b0001, {Z, Z, Z, s(1,0,'h30)},                    4'b0001, 4'd7},  // R7 lone hit
      '{2'b00, 4'b0011, {Z, Z, s(0,2,'h60), s(1,0,'h30)},          4'b0001, 4'd4},  // R4 other-cs miss does not cap
      '{2'b00, 4'b0001, {Z, Z, Z, s(1,0,'h30)},                    4'b0001, 4'd7},  // R7 saturated, still granted
      '{2'b00, 4'b0010, {Z, Z, s(0,2,'h60), Z},                    4'b0010, 4'd6},  // R6 miss on cs0
      '{2'b00, 4'b1100, {s(1,1,'h70), s(1,0,'h30), Z, Z},          4'b1000, 4'd6},  // R6 cs1 count kept
      '{2'b00, 4'b0011, {Z, Z, s(0,2,'h60), s(0,2,'h40)},          4'b0010, 4'd9},  // R9 new row hit, old row miss
      '{2'b01, 4'b0011, {Z, Z, s(0,0,'h11), s(0,2,'h60)},          4'b0001, 4'd5},  // R5 limit 4, hit 2
      '{2'b01, 4'b0011, {Z, Z, s(0,0,'h11), s(0,2,'h60)},          4'b0001, 4'd5},  // R5 hit 3
      '{2'b01, 4'b0011, {Z, Z, s(0,0,'h11), s(0,2,'h60)},          4'b0001, 4'd5},  // R5 hit 4
      '{2'b01, 4'b0011, {Z, Z, s(0,0,'h11), s(0,2,'h60)},          4'b0010, 4'd5}   // R5 miss after 4
   };

   task automatic drive(input logic [1:0] l, input logic [3:0] v, input logic [3:0][10:0] sl);
      lim_sel   = l;
      req_valid = v;
      for (int i = 0; i < 4; i++) begin
         req_cs[i]          = sl[i][10];
         req_bank[i*2 +: 2] = sl[i][9:8];
         req_row[i*8 +: 8]  = sl[i][7:0];
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input int tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hit_run(input logic [1:0] l, input logic [7:0] miss_row, input int want);
      int  hits;
      bit  done;
      hits = 0;
      done = 1'b0;
      drive(l, 4'b1100, {s(0,0,int'(miss_row)), s(0,2,'h60), Z, Z});
      for (int k = 0; k < 40 && !done; k++) begin
         step();
         if (grant_valid && grant == 4'b0100)      hits++;
         else if (grant_valid && grant == 4'b1000) done = 1'b1;
      end
      // R5: hits granted before the pending miss equals the decoded limit
      check(done && hits == want, 5, hits, want);
   endtask

   initial begin
      drive(2'b10, 4'b0000, '0);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R10: outputs quiet under reset
      check(!grant_valid && grant == 4'b0000, 10, {grant_valid, grant}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         drive(TBL[v].lim, TBL[v].vld, TBL[v].slot);
         step();
         check(grant_valid && grant == TBL[v].exp, int'(TBL[v].tag),
               {grant_valid, grant}, {1'b1, TBL[v].exp});
      end

      hit_run(2'b10, 8'h99, 8);   // R5 code 10 -> 8
      hit_run(2'b11, 8'h77, 16);  // R5 code 11 -> 16

      // R11: no request, no grant
      drive(2'b10, 4'b0000, '0);
      step();
      check(!grant_valid && grant == 4'b0000, 11, {grant_valid, grant}, 0);

      // R10: reset mid-run clears the table and pointer
      rst_n = 1'b0;
      drive(2'b10, 4'b0011, {Z, Z, s(0,2,'h60), s(0,3,'h01)});
      step();
      step();
      check(!grant_valid && grant == 4'b0000, 10, {grant_valid, grant}, 0);
      rst_n = 1'b1;
      step();
      // row 0x60 was open before reset; both slots are now misses, slot 0 first
      check(grant_valid && grant == 4'b0001, 10, {grant_valid, grant}, 5'h11);
      step();
      // R1: slot 0 row now open -> hit wins though pointer starts at slot 1
      check(grant_valid && grant == 4'b0001, 1, {grant_valid, grant}, 5'h11);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule